// File: doc/BRIEF.md
# Clock Multiplier Bring-Up Sequencer

This block brings an external clock multiplier up under software control. Software writes a pre-divider ratio, a multiplier and a post-divider ratio, together with the reference frequency in MHz and a flag that tells whether the reference comes from the internal oscillator or from an external source. The block checks the request against the allowed ranges before it applies anything. A request that fails is refused with an error flag, and the settings already applied stay in place.

An accepted request first drops the multiplier into bypass and holds its reset for at least 1000 ns. That hold is counted in controller cycles from a clock-period parameter and rounded up. Once the reset is released, the block counts reference cycles for a lock interval of ceil(2000 × N / M), where N is the pre-divider ratio and M is the multiplier. Only when that interval has run out does it enable the multiplied clock path. The controller runs on the reference clock.

Any new write, valid or not, returns the sequencer to bypass with the enable removed. A valid write then repeats the reset hold and the full lock wait.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset, pll_rst is 1 and pll_en, busy, locked and cfg_err are 0. The applied settings are pre-divider 1, multiplier 20 and post-divider 1.
- R2: A write is refused (cfg_err=1) when the pre-divider is outside 1..32, the multiplier is outside 4..32, or the post-divider is outside 1..32. All fields are plain binary ratio values.
- R3: A write is refused when ref/prediv is below 12 MHz. It is also refused when ref/prediv exceeds 30 MHz with cfg_ext_ref=0, or exceeds 50 MHz with cfg_ext_ref=1. The check uses exact integer cross-multiplication.
- R4: A write is refused when ref × mult / prediv is below 300 MHz or above 600 MHz. Both ends of the range are accepted.
- R5: In the cycle after an accepted write, cfg_err is 0, the new settings appear on pll_prediv, pll_mult and pll_postdiv, and busy is 1. busy stays 1 until locked rises.
- R6: After an accepted write, pll_rst stays 1 for RST_CYC+1 cycles, where RST_CYC = ceil(1000 / CLK_PERIOD_NS). The default is 25.
- R7: With the write sampled at edge 0, pll_en rises at edge RST_CYC+L+1, where L = ceil(2000 × prediv / mult). The result is rounded up when the division is not exact.
- R8: Any write, in any state, forces pll_en and locked to 0 and pll_rst to 1 from the next cycle.
- R9: locked always equals pll_en, and busy and locked are never 1 together.
- R10: A refused write leaves the applied settings unchanged and leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference / controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_prediv | input | FW | Requested pre-divider ratio |
| cfg_mult | input | FW | Requested multiplier |
| cfg_postdiv | input | FW | Requested post-divider ratio |
| cfg_ref_mhz | input | REF_W | Reference frequency in MHz |
| cfg_ext_ref | input | 1 | 1 = external reference source, 0 = internal oscillator |
| pll_rst | output | 1 | Reset to the multiplier (1 = held in reset / bypass) |
| pll_en | output | 1 | Enable for the multiplied clock path |
| pll_prediv | output | FW | Applied pre-divider ratio |
| pll_mult | output | FW | Applied multiplier |
| pll_postdiv | output | FW | Applied post-divider ratio |
| busy | output | 1 | Sequence in progress |
| locked | output | 1 | Multiplied path enabled |
| cfg_err | output | 1 | Last write was refused |

## Verification
The assertions assume that cfg_wr is a strobe sampled only on clock edges and that the configuration fields are stable while it is high. They also assume that the reference-clock frequency does not change without a fresh write. The bench drives every field at the falling edge and holds it over the sampling edge. It raises cfg_wr for exactly one cycle and always pairs a reference change with a new write. Because the lock check depends on this, the bench also never writes a multiplier of zero together with an accepted configuration.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    ST_BYPASS    = 2'd0,
    ST_RST_HOLD  = 2'd1,
    ST_LOCK_WAIT = 2'd2,
    ST_LOCKED    = 2'd3
  } seq_state_t;

  localparam int PRE_MIN     = 1;
  localparam int PRE_MAX     = 32;
  localparam int MUL_MIN     = 4;
  localparam int MUL_MAX     = 32;
  localparam int POST_MIN    = 1;
  localparam int POST_MAX    = 32;
  localparam int FIN_MIN     = 12;
  localparam int FIN_MAX_INT = 30;
  localparam int FIN_MAX_EXT = 50;
  localparam int FOUT_MIN    = 300;
  localparam int FOUT_MAX    = 600;
  localparam int LOCK_K      = 2000;

  // ceil(LOCK_K * n / m), zero for a zero multiplier
  function automatic int lock_cycles(int n, int m);
    if (m <= 0) return 0;
    return (LOCK_K * n + m - 1) / m;
  endfunction

  // ceil(ns / period)
  function automatic int ns_to_cycles(int ns, int period);
    return (ns + period - 1) / period;
  endfunction

  // full range and frequency validation in integer MHz
  function automatic logic cfg_valid(int n, int m, int p, int r, logic ext);
    int lim;
    lim = ext ? FIN_MAX_EXT : FIN_MAX_INT;
    if (n < PRE_MIN || n > PRE_MAX) return 1'b0;
    if (m < MUL_MIN || m > MUL_MAX) return 1'b0;
    if (p < POST_MIN || p > POST_MAX) return 1'b0;
    if (r < FIN_MIN * n) return 1'b0;
    if (r > lim * n) return 1'b0;
    if (r * m < FOUT_MIN * n) return 1'b0;
    if (r * m > FOUT_MAX * n) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/pll_cfg_check.sv
module pll_cfg_check #(
  parameter int FW    = 6,
  parameter int REF_W = 8
) (
  input  logic [FW-1:0]    prediv,
  input  logic [FW-1:0]    mult,
  input  logic [FW-1:0]    postdiv,
  input  logic [REF_W-1:0] ref_mhz,
  input  logic             ext_ref,
  output logic             ok
);
  import pll_seq_pkg::*;

  always_comb begin
    ok = cfg_valid(int'(prediv), int'(mult), int'(postdiv), int'(ref_mhz), ext_ref);
  end

endmodule

// File: rtl/pll_lock_calc.sv
module pll_lock_calc #(
  parameter int FW    = 6,
  parameter int CNT_W = 14
) (
  input  logic [FW-1:0]    prediv,
  input  logic [FW-1:0]    mult,
  output logic [CNT_W-1:0] lock_len
);
  import pll_seq_pkg::*;

  always_comb begin
    lock_len = CNT_W'(lock_cycles(int'(prediv), int'(mult)));
  end

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm #(
  parameter int CNT_W   = 14,
  parameter int RST_CYC = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             ok,
  input  logic [CNT_W-1:0] lock_len,
  output pll_seq_pkg::seq_state_t state,
  output logic             pend,
  output logic             hold_done,
  output logic             lock_done
);
  import pll_seq_pkg::*;

  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign hold_done = (state == ST_RST_HOLD)  && (cnt == '0);
  assign lock_done = (state == ST_LOCK_WAIT) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_BYPASS;
      pend  <= 1'b0;
      cnt   <= '0;
    end else if (wr) begin
      state <= ST_BYPASS;
      pend  <= ok;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_BYPASS: begin
          if (pend) begin
            state <= ST_RST_HOLD;
            pend  <= 1'b0;
            cnt   <= HOLD_LAST;
          end
        end
        ST_RST_HOLD: begin
          if (hold_done) begin
            state <= ST_LOCK_WAIT;
            cnt   <= lock_len - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_LOCK_WAIT: begin
          if (lock_done) state <= ST_LOCKED;
          else           cnt   <= cnt - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl #(
  parameter int FW            = 6,
  parameter int REF_W         = 8,
  parameter int CLK_PERIOD_NS = 40,
  parameter int RST_HOLD_NS   = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [FW-1:0]    cfg_prediv,
  input  logic [FW-1:0]    cfg_mult,
  input  logic [FW-1:0]    cfg_postdiv,
  input  logic [REF_W-1:0] cfg_ref_mhz,
  input  logic             cfg_ext_ref,
  output logic             pll_rst,
  output logic             pll_en,
  output logic [FW-1:0]    pll_prediv,
  output logic [FW-1:0]    pll_mult,
  output logic [FW-1:0]    pll_postdiv,
  output logic             busy,
  output logic             locked,
  output logic             cfg_err
);
  import pll_seq_pkg::*;

  localparam int RST_CYC = ns_to_cycles(RST_HOLD_NS, CLK_PERIOD_NS);
  localparam int MAX_LOCK = lock_cycles(PRE_MAX, MUL_MIN);
  localparam int CNT_W = $clog2(((MAX_LOCK > RST_CYC) ? MAX_LOCK : RST_CYC) + 1);

  logic             cfg_ok;
  logic             pend;
  logic             hold_done;
  logic             lock_done;
  logic [CNT_W-1:0] lock_len;
  seq_state_t       state;

  pll_cfg_check #(.FW(FW), .REF_W(REF_W)) u_check (
    .prediv  (cfg_prediv),
    .mult    (cfg_mult),
    .postdiv (cfg_postdiv),
    .ref_mhz (cfg_ref_mhz),
    .ext_ref (cfg_ext_ref),
    .ok      (cfg_ok)
  );

  pll_lock_calc #(.FW(FW), .CNT_W(CNT_W)) u_lock (
    .prediv   (pll_prediv),
    .mult     (pll_mult),
    .lock_len (lock_len)
  );

  pll_seq_fsm #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wr        (cfg_wr),
    .ok        (cfg_ok),
    .lock_len  (lock_len),
    .state     (state),
    .pend      (pend),
    .hold_done (hold_done),
    .lock_done (lock_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_prediv  <= FW'(1);
      pll_mult    <= FW'(20);
      pll_postdiv <= FW'(1);
      cfg_err     <= 1'b0;
    end else if (cfg_wr) begin
      cfg_err <= !cfg_ok;
      if (cfg_ok) begin
        pll_prediv  <= cfg_prediv;
        pll_mult    <= cfg_mult;
        pll_postdiv <= cfg_postdiv;
      end
    end
  end

  assign pll_rst = (state == ST_BYPASS) || (state == ST_RST_HOLD);
  assign pll_en  = (state == ST_LOCKED);
  assign locked  = (state == ST_LOCKED);
  assign busy    = pend || (state == ST_RST_HOLD) || (state == ST_LOCK_WAIT);

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter int FW      = 6,
  parameter int RST_CYC = 25
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_wr,
  input logic          cfg_ok,
  input logic          pll_rst,
  input logic          pll_en,
  input logic          busy,
  input logic          locked,
  input logic [FW-1:0] pll_prediv,
  input logic [FW-1:0] pll_mult,
  input logic          lock_done
);
  import pll_seq_pkg::*;

  int rst_run;
  int low_run;
  int need;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_run <= 0;
      low_run <= 0;
    end else begin
      rst_run <= pll_rst ? rst_run + 1 : 0;
      low_run <= pll_rst ? 0 : low_run + 1;
    end
  end

  always_comb need = lock_cycles(int'(pll_prediv), int'(pll_mult));

  // R8
  wr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (!pll_en && !locked && pll_rst));

  // R5
  busy_go_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_ok) |=> busy);

  // R10
  bad_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_ok) |=> ($stable(pll_mult) && $stable(pll_prediv) && !busy));

  // R6
  rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_rst) |-> (rst_run >= RST_CYC));

  // R7
  lock_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en) |-> (low_run >= need));

  // R7
  en_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en) |-> $past(lock_done));

  // R9
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (locked == pll_en) && !(busy && locked));

endmodule

bind pll_seq_ctrl pll_seq_chk #(.FW(FW), .RST_CYC(RST_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_ok     (cfg_ok),
  .pll_rst    (pll_rst),
  .pll_en     (pll_en),
  .busy       (busy),
  .locked     (locked),
  .pll_prediv (pll_prediv),
  .pll_mult   (pll_mult),
  .lock_done  (lock_done)
);

// File: tb/sim_pll_seq_ctrl.sv
module sim_pll_seq_ctrl;
  localparam int TCLK = 10;
  localparam int FW = 6;
  localparam int REF_W = 8;
  localparam int PER_NS = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [FW-1:0] cfg_prediv = '0, cfg_mult = '0, cfg_postdiv = '0;
  logic [REF_W-1:0] cfg_ref_mhz = '0;
  logic cfg_ext_ref = 1'b0;
  logic pll_rst, pll_en, busy, locked, cfg_err;
  logic [FW-1:0] pll_prediv, pll_mult, pll_postdiv;

  int n_chk = 0;
  int n_bad = 0;
  int hold_cyc;

  always #(TCLK/2) clk = ~clk;

  pll_seq_ctrl #(.FW(FW), .REF_W(REF_W), .CLK_PERIOD_NS(PER_NS), .RST_HOLD_NS(1000)) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_prediv(cfg_prediv), .cfg_mult(cfg_mult),
    .cfg_postdiv(cfg_postdiv), .cfg_ref_mhz(cfg_ref_mhz), .cfg_ext_ref(cfg_ext_ref),
    .pll_rst(pll_rst), .pll_en(pll_en), .pll_prediv(pll_prediv), .pll_mult(pll_mult),
    .pll_postdiv(pll_postdiv), .busy(busy), .locked(locked), .cfg_err(cfg_err));

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_lock(int n, int m);
    int q;
    q = (2000 * n) / m;
    if ((2000 * n) % m != 0) q = q + 1;
    return q;
  endfunction

  // write at one negedge; returns at the negedge after the sampling edge
  task automatic wr_cfg(input int n, input int m, input int p, input int r, input bit ext);
    @(negedge clk);
    cfg_prediv = FW'(n); cfg_mult = FW'(m); cfg_postdiv = FW'(p);
    cfg_ref_mhz = REF_W'(r); cfg_ext_ref = ext; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic expect_ok_seq(input int n, input int m, input int p, input string tag);
    int lk;
    lk = exp_lock(n, m);
    chk(cfg_err == 0, {tag, " R5 err clear"}, int'(cfg_err), 0);
    chk(busy == 1, {tag, " R5 busy"}, int'(busy), 1);
    chk(int'(pll_prediv) == n && int'(pll_mult) == m && int'(pll_postdiv) == p,
        {tag, " R5 applied mult"}, int'(pll_mult), m);
    chk(pll_rst == 1 && pll_en == 0, {tag, " R8 bypass"}, int'(pll_en), 0);
    repeat (hold_cyc) @(posedge clk);
    @(negedge clk);
    chk(pll_rst == 1, {tag, " R6 rst still held"}, int'(pll_rst), 1);
    @(posedge clk); @(negedge clk);
    chk(pll_rst == 0, {tag, " R6 rst released"}, int'(pll_rst), 0);
    repeat (lk - 1) @(posedge clk);
    @(negedge clk);
    chk(pll_en == 0 && busy == 1, {tag, " R7 en low at last wait cycle"}, int'(pll_en), 0);
    @(posedge clk); @(negedge clk);
    chk(pll_en == 1, {tag, " R7 en rises"}, int'(pll_en), 1);
    chk(locked == 1 && busy == 0, {tag, " R9 locked/busy"}, int'(busy), 0);
  endtask

  task automatic expect_refused(input string tag, input int old_m);
    chk(cfg_err == 1, {tag, " err"}, int'(cfg_err), 1);
    chk(busy == 0, {tag, " R10 busy low"}, int'(busy), 0);
    chk(int'(pll_mult) == old_m, {tag, " R10 settings kept"}, int'(pll_mult), old_m);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pll_rst == 1 && pll_en == 0, {tag, " R10 stays in bypass"}, int'(pll_en), 0);
  endtask

  task automatic t_reset();
    chk(pll_rst == 1, "R1 pll_rst", int'(pll_rst), 1);
    chk(pll_en == 0 && busy == 0 && locked == 0 && cfg_err == 0, "R1 outputs idle",
        int'(busy), 0);
    chk(pll_prediv == 1 && pll_mult == 20 && pll_postdiv == 1, "R1 default mult",
        int'(pll_mult), 20);
  endtask

  task automatic t_basic();
    wr_cfg(1, 20, 1, 25, 0);
    expect_ok_seq(1, 20, 1, "basic");
  endtask

  task automatic t_bounds();
    wr_cfg(2, 25, 4, 24, 0);           // fin 12, fout 300
    expect_ok_seq(2, 25, 4, "R4 low edge R3 fin 12");
    wr_cfg(1, 12, 32, 50, 1);          // fin 50 ext, fout 600, lock rounds up
    expect_ok_seq(1, 12, 32, "R4 high edge R3 ext R7 round");
    wr_cfg(3, 7, 1, 90, 1);            // fin 30, fout 210 -> refused
    expect_refused("R4 fout low", 12);
  endtask

  task automatic t_refuse();
    int cur;
    wr_cfg(1, 20, 1, 25, 0);
    expect_ok_seq(1, 20, 1, "pre-refuse");
    cur = 20;
    wr_cfg(1, 20, 1, 50, 0); expect_refused("R3 fin over internal", cur);
    wr_cfg(2, 30, 1, 20, 0); expect_refused("R3 fin under 12", cur);
    wr_cfg(1, 25, 1, 25, 0); expect_refused("R4 fout over 600", cur);
    wr_cfg(1, 3, 1, 25, 0);  expect_refused("R2 mult 3", cur);
    wr_cfg(33, 20, 1, 25, 0); expect_refused("R2 prediv 33", cur);
    wr_cfg(1, 20, 0, 25, 0); expect_refused("R2 postdiv 0", cur);
  endtask

  task automatic t_restart();
    wr_cfg(1, 20, 1, 25, 0);
    repeat (hold_cyc + 10) @(posedge clk);
    @(negedge clk);
    chk(pll_rst == 0 && pll_en == 0, "R7 mid wait", int'(pll_en), 0);
    wr_cfg(2, 24, 2, 25, 0);
    expect_ok_seq(2, 24, 2, "R8 restart mid wait");
    wr_cfg(1, 25, 1, 25, 0);       // refused while locked
    chk(pll_en == 0 && locked == 0 && pll_rst == 1, "R8 refused write drops enable",
        int'(pll_en), 0);
    expect_refused("R10 refused while locked", 24);
  endtask

  initial begin
    hold_cyc = 1000 / PER_NS;
    if (1000 % PER_NS != 0) hold_cyc = hold_cyc + 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_basic();
    t_bounds();
    t_refuse();
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(TCLK * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule